// File: doc/BRIEF.md
# Serial Register-Access Slave

This block lets an external host read and write a bank of 8-bit registers over a four-wire serial bus made of an active-low chip select, a serial clock, a data-in line and a data-out line. Every transaction is a 16-bit frame. The host holds chip select low, clocks the bits in with the most significant bit first, and then raises chip select. The frame's fields are a direction flag, a 7-bit register address and a data byte. The command takes effect on the rising edge of chip select.

Read data comes back one frame late. A read command loads the addressed register into the low byte of the internal shift register. During the next frame (a no-op will do), the host sees the echoed command byte first and then the register contents. The serial pins are brought into the system clock domain by a synchronizer, and all logic runs on that clock. The serial clock must therefore stay at least a few system clocks in each level.

Top module: `spi_reg_slave`

## Requirements
- R1: A synchronous active-low reset clears every register to 0x00, clears the shift register and frame state, and drives data out low.
- R2: Data in is sampled on each rising serial-clock edge while chip select is low, with the most significant bit first. A command executes only when chip select rises.
- R3: A frame with bit 15 = 0 writes bits 7..0 into the register whose address is in bits 14..8. The written value appears on the `regs_o` slice for that address (address N occupies bits 8N+7..8N).
- R4: A frame with bit 15 = 1 changes no register and ignores its data byte. It preloads the addressed register into the low byte of the shift register. In the next frame, data out carries that frame's command byte as bits 1..8 and the register contents as bits 9..16.
- R5: Data out presents the top bit of the shift register. It changes only after a falling serial-clock edge, or when chip select falls, and it stays stable while the serial clock is high.
- R6: Data out is low whenever chip select is high.
- R7: When more than 16 bits are clocked in within one frame, only the last 16 bits are decoded.
- R8: A frame with fewer than 16 bits when chip select rises is discarded. It writes no register.
- R9: Address 0x00 is a no-op. So is any address at or above NUM_REGS. A write to such an address changes nothing, and a read of it returns 0x00.
- R10: The frame executes the same way whether chip select rises while the serial clock is still high after the last bit or after the clock has returned low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is clocked here |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| regs_o | output | NUM_REGS*8 | Current contents of the register bank, address N in bits 8N+7..8N |

## Verification
The hardest case to reach is the one-frame-late read return. Its data is visible only while a second, unrelated frame is being clocked. That frame's first byte has to be the echoed command byte, not stale data. The bench issues a read and then a no-op. It captures the complete 16-bit data-out stream of the no-op and compares both bytes. The discarded short frame and the overlong frame both need chip select to rise at an unusual bit count. They are built by driving a chosen number of clocks inside one chip-select window.

// File: rtl/spi_reg_pkg.sv
// Package: shared frame layout and widths for the serial register slave.
// Assumes a 16-bit frame: direction flag, 7-bit address, 8-bit data.
package spi_reg_pkg;
    localparam int FRAME_W = 16;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Module: brings the three serial input pins into the system clock domain
// and derives single-cycle edge strobes for serial clock and chip select.
// Assumes each serial level is held for more than STAGES+1 system clocks.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sclk_i,
    input  logic mosi_i,
    output logic cs_n_s,
    output logic mosi_s,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] sck_pipe;
    logic [STAGES-1:0] di_pipe;
    logic              cs_prev;
    logic              sck_prev;

    // Purpose: shift each pin through its synchronizer chain, reset to idle levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_pipe  <= '1;
            sck_pipe <= '0;
            di_pipe  <= '0;
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_pipe  <= {cs_pipe[STAGES-2:0], cs_n_i};
            sck_pipe <= {sck_pipe[STAGES-2:0], sclk_i};
            di_pipe  <= {di_pipe[STAGES-2:0], mosi_i};
            cs_prev  <= cs_pipe[TOP];
            sck_prev <= sck_pipe[TOP];
        end
    end

    // Purpose: expose synchronized levels and edge strobes.
    always_comb begin
        cs_n_s    = cs_pipe[TOP];
        mosi_s    = di_pipe[TOP];
        sclk_rise = sck_pipe[TOP] & ~sck_prev;
        sclk_fall = ~sck_pipe[TOP] & sck_prev;
        cs_rise   = cs_pipe[TOP] & ~cs_prev;
        cs_fall   = ~cs_pipe[TOP] & cs_prev;
    end
endmodule

// File: rtl/spi_frame_shifter.sv
// Module: 16-bit shift register with bit counting, frame commit on chip-select
// rise, read preload of the low byte, and the data-out register.
// Assumes edge strobes from spi_pin_sync; never more than one per cycle.
module spi_frame_shifter
    import spi_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic [DATA_W-1:0] preload_data,
    output frame_t            frame,
    output logic              frame_valid,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              miso
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt_q;

    // Purpose: a frame is committed only on chip-select rise after a full count.
    always_comb begin
        frame       = frame_t'(shreg);
        frame_valid = cs_rise && (cnt_q == FULL);
        bit_cnt     = cnt_q;
    end

    // Purpose: shift in data bits, count them (saturating), preload on read commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt_q <= '0;
        end else if (cs_fall) begin
            cnt_q <= '0;
        end else if (sclk_rise && !cs_n_s) begin
            shreg <= {shreg[FRAME_W-2:0], mosi_s};
            cnt_q <= (cnt_q == FULL) ? FULL : cnt_q + 1'b1;
        end else if (frame_valid && frame.rd) begin
            shreg[DATA_W-1:0] <= preload_data;
        end
    end

    // Purpose: drive data out from the shift register top bit, low when deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miso <= 1'b0;
        end else if (cs_n_s) begin
            miso <= 1'b0;
        end else if (cs_fall || sclk_fall) begin
            miso <= shreg[FRAME_W-1];
        end
    end
endmodule

// File: rtl/spi_reg_bank.sv
// Module: bank of 8-bit registers, address 0 and addresses >= NUM_REGS unstored.
// Assumes a single write port strobe and a combinational read port.
module spi_reg_bank
    import spi_reg_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);
    logic [DATA_W-1:0] mem [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == 0) begin : g_noop
            // Purpose: address zero is a no-op and never holds data.
            always_comb mem[i] = '0;
        end else begin : g_store
            // Purpose: hold one register, loaded on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[i] <= '0;
                end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
                    mem[i] <= wr_data;
                end
            end
        end
        assign regs_o[i*DATA_W +: DATA_W] = mem[i];
    end

    // Purpose: select read data, zero for unmapped addresses.
    always_comb begin
        rd_data = '0;
        for (int j = 0; j < NUM_REGS; j++) begin
            if (rd_addr == ADDR_W'(j)) rd_data = mem[j];
        end
    end
endmodule

// File: rtl/spi_reg_slave.sv
// Module: top of the serial register-access slave. Connects the pin
// synchronizer, frame shifter and register bank.
// Assumes the serial clock is much slower than clk.
module spi_reg_slave
    import spi_reg_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_cs_n,
    input  logic                       spi_sclk,
    input  logic                       spi_mosi,
    output logic                       spi_miso,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);
    logic              cs_n_s, mosi_s, sclk_rise, sclk_fall, cs_fall, cs_rise;
    frame_t            frame;
    logic              frame_valid;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .cs_n_i(spi_cs_n), .sclk_i(spi_sclk), .mosi_i(spi_mosi),
        .cs_n_s(cs_n_s), .mosi_s(mosi_s),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise)
    );

    spi_frame_shifter u_shift (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s(cs_n_s), .mosi_s(mosi_s),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise),
        .preload_data(rd_data),
        .frame(frame), .frame_valid(frame_valid),
        .bit_cnt(bit_cnt), .miso(spi_miso)
    );

    // Purpose: a committed frame with a clear direction flag is a write.
    always_comb wr_en = frame_valid && !frame.rd;

    spi_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(frame.addr), .wr_data(frame.data),
        .rd_addr(frame.addr), .rd_data(rd_data),
        .regs_o(regs_o)
    );
endmodule

// File: rtl/spi_reg_slave_chk.sv
// Module: assertion checker for spi_reg_slave, attached by bind below.
// Assumes the internal signal names of the top module.
module spi_reg_slave_chk
    import spi_reg_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cs_n_s,
    input logic                       cs_rise,
    input logic                       frame_valid,
    input logic                       frame_rd,
    input logic [CNT_W-1:0]           bit_cnt,
    input logic                       spi_miso,
    input logic [NUM_REGS*DATA_W-1:0] regs_o
);
    AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !spi_miso); // R6

    AST_QUIET_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> $stable(regs_o)); // R8

    AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && frame_rd) |=> $stable(regs_o)); // R4

    AST_COMMIT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> cs_rise); // R2

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_W)); // R7
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(cs_n_s), .cs_rise(cs_rise),
    .frame_valid(frame_valid), .frame_rd(frame.rd),
    .bit_cnt(bit_cnt), .spi_miso(spi_miso), .regs_o(regs_o)
);

// File: tb/sim_spi_reg_slave.sv
// Directed bench for spi_reg_slave: one task per scenario, each checking itself.
module sim_spi_reg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int NREG       = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic cs_n = 1, sclk = 0, mosi = 0;
    logic miso;
    logic [NREG*8-1:0] regs;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] mdl [NREG];

    spi_reg_slave #(.NUM_REGS(NREG)) u0 (
        .clk(clk), .rst_n(rst_n),
        .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_miso(miso), .regs_o(regs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive n bits of word MSB first; capture data out before each rising edge.
    task automatic xfer(input int n, input logic [31:0] word, input bit end_high,
                        output logic [31:0] got, output bit edge_ok);
        logic lo;
        got = 0;
        edge_ok = 1;
        @(negedge clk) cs_n = 0;
        for (int i = n - 1; i >= 0; i--) begin
            mosi = word[i];
            repeat (HALF) @(negedge clk);
            lo = miso;
            got = {got[30:0], miso};
            sclk = 1;
            repeat (HALF) @(negedge clk);
            if (miso !== lo) edge_ok = 0;
            if (!(i == 0 && end_high)) sclk = 0;
        end
        if (!end_high) repeat (HALF) @(negedge clk);
        cs_n = 1;
        repeat (HALF) @(negedge clk);
        sclk = 0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic check_bank(input string req);
        for (int k = 0; k < NREG; k++) chk(req, {24'h0, regs[k*8 +: 8]}, {24'h0, mdl[k]});
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d, input bit end_high);
        logic [31:0] g; bit e;
        xfer(16, {16'h0, 1'b0, a, d}, end_high, g, e);
        if (a != 0 && a < NREG) mdl[a] = d;
    endtask

    // Read: issue read, then a no-op, return the no-op's captured stream.
    task automatic do_read(input logic [6:0] a, input logic [7:0] dummy, output logic [15:0] s);
        logic [31:0] g; bit e;
        xfer(16, {16'h0, 1'b1, a, dummy}, 0, g, e);
        xfer(16, 32'h0, 0, g, e);
        s = g[15:0];
    endtask

    task automatic t_reset;
        rst_n = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        for (int k = 0; k < NREG; k++) mdl[k] = 8'h00;
        chk("R1 miso", {31'h0, miso}, 32'h0);
        check_bank("R1 bank");
    endtask

    task automatic t_write_read;
        logic [15:0] s;
        do_write(7'd3, 8'hA5, 0);
        check_bank("R3 write");
        do_write(7'd15, 8'h5A, 0);
        do_write(7'd1, 8'h81, 0);
        check_bank("R3 patterns");
        do_read(7'd3, 8'hFF, s);
        chk("R4 echo", {16'h0, s[15:8]}, 32'h83);
        chk("R4 data", {16'h0, s[7:0]}, 32'hA5);
        check_bank("R4 no change");
        do_read(7'd15, 8'h00, s);
        chk("R4 data15", {16'h0, s}, 32'h8F5A);
    endtask

    task automatic t_edges;
        logic [31:0] g; bit e;
        xfer(16, 32'h0542, 0, g, e);
        mdl[5] = 8'h42;
        chk("R5 stable while high", {31'h0, e}, 32'h1);
        repeat (2) @(negedge clk);
        chk("R6 idle low", {31'h0, miso}, 32'h0);
        check_bank("R2 msb first");
    endtask

    task automatic t_long_short;
        logic [31:0] g; bit e;
        xfer(20, 32'hF063C, 0, g, e);
        mdl[6] = 8'h3C;
        check_bank("R7 overlong");
        xfer(12, 32'h07E, 0, g, e);
        check_bank("R8 short");
        xfer(15, 32'h0477, 0, g, e);
        check_bank("R8 fifteen");
    endtask

    task automatic t_noop_addr;
        logic [15:0] s;
        do_write(7'd0, 8'hFF, 0);
        do_write(7'h7F, 8'hEE, 0);
        do_write(7'd16, 8'hDD, 0);
        check_bank("R9 ignored writes");
        do_read(7'd0, 8'h00, s);
        chk("R9 read zero", {24'h0, s[7:0]}, 32'h0);
        do_read(7'h7F, 8'h00, s);
        chk("R9 read unmapped", {24'h0, s[7:0]}, 32'h0);
    endtask

    task automatic t_cs_early;
        logic [15:0] s;
        do_write(7'd9, 8'hC3, 1);
        check_bank("R10 cs while sclk high");
        do_read(7'd9, 8'h00, s);
        chk("R10 readback", {24'h0, s[7:0]}, 32'hC3);
    endtask

    task automatic t_reset_again;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        for (int k = 0; k < NREG; k++) mdl[k] = 8'h00;
        check_bank("R1 reset clears");
    endtask

    initial begin
        t_reset;
        t_write_read;
        t_edges;
        t_long_short;
        t_noop_addr;
        t_cs_early;
        t_reset_again;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule